// File: doc/BRIEF.md
# Destructive-Read Core Memory Sequencer

This controller sits between a host request port and a coincident-current magnetic core stack. It drives the addressed X and Y select lines, the per-plane inhibit lines and the sampling of the per-plane sense lines for every access. Sensing a core erases it. Each access therefore starts with a clear phase, in which the X/Y lines are driven in the zero direction and sense pulses are gathered. A restore phase follows, in which the lines are driven in the one direction. Planes that must hold a 0 are inhibited during that phase.

For a read, the restore phase writes back the word that was captured, so the stored contents are the same after the access as before it. For a write, the clear phase runs the same way but its sensed data is discarded, and the restore phase stores the host data. During the restore phase each plane that is written to 1 must produce a sense pulse as confirmation. If any such pulse is missing, an error flag is raised for that access.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A host that sees `req_ready` low must hold its request. Responses are a one-cycle `rsp_valid` pulse with no back-pressure, so the host must accept the response in the cycle it appears.

Top module: `core_seq_ctrl`

## Requirements
- R1: While reset is held, `req_ready` is 1 and `drv_en`, `inhibit`, `rsp_valid` and `cyc_done` are all 0.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` then stays 0 from that edge through the `cyc_done` cycle.
- R3: The clear phase drives `drv_en`=1 and `drv_dir`=0 for DRIVE_CYC+SENSE_WIN cycles. `x_sel` is one-hot at index `req_addr[X_BITS-1:0]` and `y_sel` is one-hot at index `req_addr[ADDR_W-1:X_BITS]`.
- R4: The sense window is the last SENSE_WIN cycles of the clear phase. A pulse on a plane in any cycle of the window sets that bit of the captured word. The capture is cleared when each request is taken.
- R5: A read is followed by a restore phase with `drv_dir`=1 for RESTORE_CYC cycles and `inhibit` = inverse of the captured word. A later read of the same address returns the same word.
- R6: A write runs the same clear phase and ignores its sensed data. The restore phase uses `inhibit` = inverse of the write data. The write response carries `rsp_rdata`=0.
- R7: With EARLY_RSP=1, a read response appears DRIVE_CYC+SENSE_WIN cycles after the accepting edge, in the first restore cycle, and includes a pulse from the last window cycle. Writes respond in the `cyc_done` cycle, which comes DRIVE_CYC+SENSE_WIN+RESTORE_CYC cycles after the accepting edge. `rsp_valid` lasts one cycle.
- R8: `cyc_done` is high for one cycle per access. `cyc_err` is 1 in that cycle exactly when some bit written as 1 gave no sense pulse during the restore phase.
- R9: `inhibit` is nonzero only while `drv_en`=1 and `drv_dir`=1.
- R10: When `drv_en`=0, `x_sel` and `y_sel` are all zeros. While `drv_en` stays high, the selection does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | X_BITS+Y_BITS | Word address, X index in the low bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| cyc_done | output | 1 | One-cycle end-of-access strobe |
| cyc_err | output | 1 | Missing restore confirmation, valid with cyc_done |
| drv_en | output | 1 | Select drive active |
| drv_dir | output | 1 | Drive polarity: 0 = zero direction, 1 = one direction |
| x_sel | output | 2**X_BITS | One-hot X select lines |
| y_sel | output | 2**Y_BITS | One-hot Y select lines |
| inhibit | output | DATA_W | Per-plane inhibit, restore phase only |
| sense | input | DATA_W | Per-plane sense pulses |

## Verification
Two events can land on the same clock edge. One is the early read response, which is built from the captured word. The other is a sense pulse arriving in the last cycle of the window, at the same edge where the response register loads and the restore drive starts. The bench provokes this with its behavioural core stack. It sweeps the sense delay so that pulses fall in the first, middle and last window cycle. For each delay it checks that the returned word and the restored contents hold every pulsed bit, and that the restore inhibit pattern matches that word. A second overlap is between confirmation and error reporting. The bench suppresses the confirmation pulse of one plane and checks that `cyc_err` depends only on whether that plane was written as 1.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CLEAR,
    SEQ_LISTEN,
    SEQ_RESTORE,
    SEQ_DONE
  } seq_state_e;
endpackage

// File: rtl/core_seq_onehot.sv
module core_seq_onehot #(
  parameter int SEL_BITS = 2
) (
  input  logic                     en,
  input  logic [SEL_BITS-1:0]      idx,
  output logic [(1<<SEL_BITS)-1:0] lines
);
  localparam int LINES = 1 << SEL_BITS;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lines[i] = en && (idx == SEL_BITS'(i));
    end
  endgenerate
endmodule

// File: rtl/core_seq_sticky.sv
module core_seq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] pulse,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              q[b] <= 1'b0;
        else if (clr)            q[b] <= 1'b0;
        else if (en && pulse[b]) q[b] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/core_seq_fsm.sv
module core_seq_fsm
  import core_seq_pkg::*;
#(
  parameter int DRIVE_CYC   = 2,
  parameter int SENSE_WIN   = 3,
  parameter int RESTORE_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output seq_state_e state,
  output logic       last
);
  localparam int MAX_AB = (DRIVE_CYC > SENSE_WIN) ? DRIVE_CYC : SENSE_WIN;
  localparam int MAX_C  = (MAX_AB > RESTORE_CYC) ? MAX_AB : RESTORE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_CLEAR;
            cnt   <= CNT_W'(DRIVE_CYC - 1);
          end
        end
        SEQ_CLEAR: begin
          if (last) begin
            state <= SEQ_LISTEN;
            cnt   <= CNT_W'(SENSE_WIN - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_LISTEN: begin
          if (last) begin
            state <= SEQ_RESTORE;
            cnt   <= CNT_W'(RESTORE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_RESTORE: begin
          if (last) state <= SEQ_DONE;
          else      cnt   <= cnt - 1'b1;
        end
        default: begin
          state <= SEQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/core_seq_ctrl.sv
module core_seq_ctrl
  import core_seq_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int X_BITS      = 2,
  parameter int Y_BITS      = 2,
  parameter int DRIVE_CYC   = 2,
  parameter int SENSE_WIN   = 3,
  parameter int RESTORE_CYC = 5,
  parameter bit EARLY_RSP   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [X_BITS+Y_BITS-1:0] req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     cyc_done,
  output logic                     cyc_err,
  output logic                     drv_en,
  output logic                     drv_dir,
  output logic [(1<<X_BITS)-1:0]   x_sel,
  output logic [(1<<Y_BITS)-1:0]   y_sel,
  output logic [DATA_W-1:0]        inhibit,
  input  logic [DATA_W-1:0]        sense
);
  localparam int ADDR_W = X_BITS + Y_BITS;

  seq_state_e         state;
  logic               last;
  logic               accept;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  cap_q;
  logic [DATA_W-1:0]  conf_q;
  logic [DATA_W-1:0]  restore_word;
  logic               in_listen;
  logic               in_restore;
  logic               listen_end;
  logic               restore_end;

  assign req_ready   = (state == SEQ_IDLE);
  assign accept      = req_valid && req_ready;
  assign in_listen   = (state == SEQ_LISTEN);
  assign in_restore  = (state == SEQ_RESTORE);
  assign listen_end  = in_listen && last;
  assign restore_end = in_restore && last;

  core_seq_fsm #(
    .DRIVE_CYC  (DRIVE_CYC),
    .SENSE_WIN  (SENSE_WIN),
    .RESTORE_CYC(RESTORE_CYC)
  ) fsm_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .state(state),
    .last (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  core_seq_sticky #(.W(DATA_W)) capture_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .en   (in_listen),
    .pulse(sense),
    .q    (cap_q)
  );

  core_seq_sticky #(.W(DATA_W)) confirm_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .en   (in_restore),
    .pulse(sense),
    .q    (conf_q)
  );

  assign restore_word = wr_q ? wdata_q : cap_q;
  assign drv_en  = (state == SEQ_CLEAR) || in_listen || in_restore;
  assign drv_dir = in_restore;
  assign inhibit = in_restore ? ~restore_word : '0;

  core_seq_onehot #(.SEL_BITS(X_BITS)) xdec_i (
    .en   (drv_en),
    .idx  (addr_q[X_BITS-1:0]),
    .lines(x_sel)
  );

  core_seq_onehot #(.SEL_BITS(Y_BITS)) ydec_i (
    .en   (drv_en),
    .idx  (addr_q[ADDR_W-1:X_BITS]),
    .lines(y_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      cyc_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      cyc_err   <= 1'b0;
      if (listen_end && !wr_q && EARLY_RSP) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= cap_q | sense;
      end
      if (restore_end) begin
        cyc_err <= |(restore_word & ~(conf_q | sense));
        if (wr_q || !EARLY_RSP) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= wr_q ? '0 : cap_q;
        end
      end
    end
  end

  assign cyc_done = (state == SEQ_DONE);
endmodule

// File: rtl/core_seq_ctrl_chk.sv
module core_seq_ctrl_chk #(
  parameter int DATA_W = 4,
  parameter int X_BITS = 2,
  parameter int Y_BITS = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   cyc_done,
  input logic                   drv_en,
  input logic                   drv_dir,
  input logic [(1<<X_BITS)-1:0] x_sel,
  input logic [(1<<Y_BITS)-1:0] y_sel,
  input logic [DATA_W-1:0]      inhibit
);
  AST_ACCEPT_STARTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> drv_en && !drv_dir && !req_ready); // R2

  AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> !req_ready); // R2

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> $onehot(x_sel) && $onehot(y_sel)); // R3

  AST_RESTORE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en && drv_dir |-> $past(drv_en)); // R5

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done && req_ready); // R8

  AST_INHIBIT_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit != '0) |-> drv_en && drv_dir); // R9

  AST_SEL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (x_sel == '0) && (y_sel == '0)); // R10

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en && $past(drv_en) |-> $stable(x_sel) && $stable(y_sel)); // R10
endmodule

bind core_seq_ctrl core_seq_ctrl_chk #(
  .DATA_W(DATA_W),
  .X_BITS(X_BITS),
  .Y_BITS(Y_BITS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .cyc_done (cyc_done),
  .drv_en   (drv_en),
  .drv_dir  (drv_dir),
  .x_sel    (x_sel),
  .y_sel    (y_sel),
  .inhibit  (inhibit)
);

// File: tb/core_seq_ctrl_tb_top.sv
module core_seq_ctrl_tb_top;
  localparam int DW  = 4;
  localparam int XB  = 2;
  localparam int YB  = 2;
  localparam int AW  = XB + YB;
  localparam int NW  = 1 << AW;
  localparam int DRV = 2;
  localparam int WIN = 3;
  localparam int RST = 5;
  localparam int RSP_EARLY = DRV + WIN + 1;
  localparam int DONE_LAT  = DRV + WIN + RST + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] sense = '0;
  logic req_ready, rsp_valid, cyc_done, cyc_err, drv_en, drv_dir;
  logic [DW-1:0] rsp_rdata, inhibit;
  logic [(1<<XB)-1:0] x_sel;
  logic [(1<<YB)-1:0] y_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  core_seq_ctrl #(
    .DATA_W(DW), .X_BITS(XB), .Y_BITS(YB),
    .DRIVE_CYC(DRV), .SENSE_WIN(WIN), .RESTORE_CYC(RST), .EARLY_RSP(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cyc_done(cyc_done), .cyc_err(cyc_err),
    .drv_en(drv_en), .drv_dir(drv_dir), .x_sel(x_sel), .y_sel(y_sel),
    .inhibit(inhibit), .sense(sense)
  );

  // Behavioural core stack: cores flip on a new drive phase, pulse after a lag.
  logic [DW-1:0] core_mem [NW];
  logic [DW-1:0] pipe [8];
  int lag = 3;
  logic [DW-1:0] drop_mask = '0;
  logic prev_en = 1'b0;
  logic prev_dir = 1'b0;

  initial begin
    for (int i = 0; i < NW; i++) core_mem[i] = '0;
    for (int i = 0; i < 8; i++) pipe[i] = '0;
  end

  always @(negedge clk) begin
    logic [DW-1:0] flip;
    int xi, yi, a;
    flip = '0;
    if (drv_en && (!prev_en || drv_dir != prev_dir)) begin
      xi = 0; yi = 0;
      for (int i = 0; i < (1<<XB); i++) if (x_sel[i]) xi = i;
      for (int i = 0; i < (1<<YB); i++) if (y_sel[i]) yi = i;
      a = yi * (1<<XB) + xi;
      if (!drv_dir) begin
        flip = core_mem[a];
        core_mem[a] = '0;
      end else begin
        flip = ~inhibit & ~core_mem[a] & ~drop_mask;
        core_mem[a] = core_mem[a] | ~inhibit;
      end
    end
    prev_en = drv_en;
    prev_dir = drv_dir;
    for (int i = 7; i > 0; i--) pipe[i] = pipe[i-1];
    pipe[0] = flip;
    sense = pipe[lag];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output bit err, output int rlat,
                        output int dlat, output bit busy_ok, output bit sel_ok,
                        output logic [DW-1:0] inh6, output int zcnt, output int ocnt,
                        output bit quiet_ok);
    int n;
    rd = '0; err = 1'b0; rlat = -1; dlat = -1; busy_ok = 1'b1; sel_ok = 1'b0;
    inh6 = '0; zcnt = 0; ocnt = 0; quiet_ok = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (n < 100) begin
      if (req_ready) busy_ok = 1'b0;
      if (n == 1)
        sel_ok = drv_en && !drv_dir &&
                 (x_sel == ((1<<XB)'(1) << ad[XB-1:0])) &&
                 (y_sel == ((1<<YB)'(1) << ad[AW-1:XB]));
      if (drv_en && !drv_dir) zcnt++;
      if (drv_en && drv_dir) ocnt++;
      if (n == RSP_EARLY) inh6 = inhibit;
      if (inhibit != '0 && !(drv_en && drv_dir)) quiet_ok = 1'b0;
      if (!drv_en && (x_sel != '0 || y_sel != '0)) quiet_ok = 1'b0;
      if (rsp_valid) begin rd = rsp_rdata; rlat = n; end
      if (cyc_done) begin err = cyc_err; dlat = n; break; end
      n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd, inh6, exp;
    bit err, busy_ok, sel_ok, quiet_ok;
    int rlat, dlat, zcnt, ocnt;

    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 1);
    chk("R1 drive idle in reset", {drv_en, inhibit, rsp_valid, cyc_done}, 0);
    rst_n = 1'b1;

    // Write sweep over every address.
    for (int a = 0; a < NW; a++) begin
      exp = DW'((a * 7 + 5) % 16);
      access(1'b1, AW'(a), exp, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
      chk("R2 busy while writing", 32'(busy_ok), 1);
      chk("R3 clear select", 32'(sel_ok), 1);
      chk("R3 clear length", 32'(zcnt), DRV + WIN);
      chk("R6 write inhibit", 32'(inh6), 32'(DW'(~exp)));
      chk("R6 write rdata zero", 32'(rd), 0);
      chk("R6 core holds write data", 32'(core_mem[a]), 32'(exp));
      chk("R7 write response latency", 32'(rlat), DONE_LAT);
      chk("R8 no error on write", 32'(err), 0);
      chk("R9 R10 idle lines quiet", 32'(quiet_ok), 1);
    end

    // Read sweep with the sense lag put in first, middle and last window cycle.
    for (int l = 2; l <= 4; l++) begin
      lag = l;
      for (int a = 0; a < NW; a++) begin
        exp = DW'((a * 7 + 5) % 16);
        access(1'b0, AW'(a), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
        chk("R4 captured word", 32'(rd), 32'(exp));
        chk("R5 restore inhibit", 32'(inh6), 32'(DW'(~exp)));
        chk("R5 restore length", 32'(ocnt), RST);
        chk("R5 contents preserved", 32'(core_mem[a]), 32'(exp));
        chk("R7 early read latency", 32'(rlat), RSP_EARLY);
        chk("R8 done latency", 32'(dlat), DONE_LAT);
        chk("R8 read no error", 32'(err), 0);
        chk("R2 busy while reading", 32'(busy_ok), 1);
      end
    end
    lag = 3;

    // Extremes of data and a second read of the same word.
    access(1'b1, AW'(9), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    access(1'b0, AW'(9), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R5 all-zero word", 32'(rd), 0);
    access(1'b1, AW'(9), '1, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R6 all-ones inhibit off", 32'(inh6), 0);
    access(1'b0, AW'(9), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    access(1'b0, AW'(9), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R5 second read all ones", 32'(rd), 32'(DW'('1)));

    // Missing confirmation on plane 2.
    drop_mask = DW'(4'b0100);
    access(1'b1, AW'(3), DW'(4'b0110), rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R8 error when written one unconfirmed", 32'(err), 1);
    access(1'b1, AW'(3), DW'(4'b1011), rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R8 no error when plane written zero", 32'(err), 0);
    access(1'b0, AW'(3), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R8 read without plane-2 one", 32'(err), 0);
    chk("R4 read data under drop", 32'(rd), 32'(4'b1011));
    access(1'b1, AW'(3), DW'(4'b0100), rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    access(1'b0, AW'(3), '0, rd, err, rlat, dlat, busy_ok, sel_ok, inh6, zcnt, ocnt, quiet_ok);
    chk("R8 read restore unconfirmed", 32'(err), 1);
    chk("R4 read data plane 2", 32'(rd), 32'(4'b0100));
    drop_mask = '0;

    @(negedge clk);
    chk("R1 R2 idle after access", 32'(req_ready), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule